// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Counter

This core keeps a 32-bit count of seconds. It is driven by a slow crystal tick that arrives as a one-cycle enable pulse in the system clock domain. A tick counter divides that enable down to a one-second strobe. The divide ratio comes from a calibration word. An optional fractional trim lengthens chosen seconds by one tick, which corrects crystal error that the integer divider cannot reach.

Software drives the core through a flat 32-bit register port. A time value written by software is not applied at once. It is held as pending and moved into the running count on the next second strobe. Software can read back the held value. A sticky status bit, which also drives the interrupt line, shows that a strobe has happened since software last cleared it. A calibration write restarts the divider, so the first strobe after it lands exactly one full period later.

Top module: `rtc_seconds_core`

## Requirements
- R1: Register map on `reg_addr` (byte offsets): 0x00 time-set write, 0x04 time-set readback, 0x08 calibration, 0x10 current seconds, 0x20 status, 0x40 control. Reading 0x04 returns the last value written to 0x00. Any offset not in this map reads as 0.
- R2: A write to 0x00 marks the value pending. It reaches 0x10 only on the next second strobe. Until that strobe, 0x10 keeps its old value.
- R3: On a strobe with no value pending, the seconds count grows by exactly one.
- R4: The tick counter advances only on cycles where `tick_en` is high. With fractional trim off, a strobe falls on the N-th tick after the counter was cleared, where N is calibration bits 15:0.
- R5: A write to 0x08 clears the tick counter and the fraction state. The next strobe then comes exactly one full period of ticks after the write.
- R6: Calibration bit 20 enables the fractional trim and bits 19:16 hold the fraction F. Each strobe adds F to a 4-bit accumulator. A carry out of that add makes the following second one tick longer, so F seconds in every 16 are lengthened. Example: with N=3 and F=8, the seconds after a calibration write last 3, 3, 4, 3 ticks.
- R7: Status bit 0 is set by every strobe. Writing 0x20 with bit 0 at 1 clears it, and writing with bit 0 at 0 has no effect. If a strobe and a clear fall in the same cycle, the set wins.
- R8: `irq` is high exactly while status bit 0 is set.
- R9: Control bit 31 (battery-switch enable) is stored and read back at 0x40. The other control bits read as 0. The bit has no effect on counting.
- R10: Synchronous reset clears the seconds count, the held time value, the pending flag, the tick and fraction state, status and control. It also loads calibration 0x198233, and calibration reads back masked to 21 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle crystal tick enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Second-elapsed interrupt, level |

## Verification
Read data is a combinational decode of `reg_addr`, so a register value can be read in the same cycle it is addressed. Register writes and the tick that completes a second both take effect at the clock edge that samples them, so the new seconds value, the status bit and `irq` are all visible in the cycle after that edge. The bench drives every input on the falling edge and holds it across one rising edge. It then reads the results on the next falling edge, one register stage after the stimulus. Period checks count the ticks delivered until 0x10 changes, which gives the tick count at which each strobe falls.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
   // Register byte offsets; software depends on these positions.
   localparam logic [7:0] OFS_SET_WR = 8'h00;
   localparam logic [7:0] OFS_SET_RD = 8'h04;
   localparam logic [7:0] OFS_CAL    = 8'h08;
   localparam logic [7:0] OFS_NOW    = 8'h10;
   localparam logic [7:0] OFS_STAT   = 8'h20;
   localparam logic [7:0] OFS_CTRL   = 8'h40;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
   parameter int TICK_W       = 16,
   parameter int FRAC_W       = 4,
   parameter bit FRAC_SUPPORT = 1'b1,
   localparam int CAL_W       = TICK_W + FRAC_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   input  logic             cal_wr,
   input  logic [CAL_W-1:0] cal_q,
   output logic             sec_stb
);
   logic [TICK_W-1:0] cnt_q;
   logic              extra_q;
   logic [TICK_W:0]   limit;
   logic              hit;

   // Period of the current second: base count plus the optional trim tick.
   assign limit   = {1'b0, cal_q[TICK_W-1:0]} + {{TICK_W{1'b0}}, extra_q};
   assign hit     = ({1'b0, cnt_q} + 1'b1) == limit;
   assign sec_stb = tick_en && hit && !cal_wr;

   always_ff @(posedge clk) begin
      if (rst || cal_wr || sec_stb) cnt_q <= '0;
      else if (tick_en)             cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (FRAC_SUPPORT) begin : g_frac
         logic [FRAC_W-1:0] acc_q;
         logic [FRAC_W:0]   acc_sum;
         assign acc_sum = {1'b0, acc_q} + {1'b0, cal_q[TICK_W +: FRAC_W]};
         always_ff @(posedge clk) begin
            if (rst || cal_wr) begin
               acc_q   <= '0;
               extra_q <= 1'b0;
            end else if (sec_stb) begin
               if (cal_q[CAL_W-1]) begin
                  acc_q   <= acc_sum[FRAC_W-1:0];
                  extra_q <= acc_sum[FRAC_W];
               end else begin
                  extra_q <= 1'b0;
               end
            end
         end
      end else begin : g_nofrac
         assign extra_q = 1'b0;
      end
   endgenerate

   assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
      cal_wr |=> (cnt_q == '0));
   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!tick_en && !cal_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_sec_count.sv
module rtc_sec_count #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              set_wr,
   input  logic [DATA_W-1:0] set_val,
   input  logic              sec_stb,
   output logic [DATA_W-1:0] set_q,
   output logic [DATA_W-1:0] now_q
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         set_q  <= '0;
         pend_q <= 1'b0;
         now_q  <= '0;
      end else begin
         if (sec_stb) now_q <= pend_q ? set_q : now_q + 1'b1;
         if (set_wr) begin
            set_q  <= set_val;
            pend_q <= 1'b1;
         end else if (sec_stb) begin
            pend_q <= 1'b0;
         end
      end
   end

   assert_load_pending_R2: assert property (@(posedge clk) disable iff (rst)
      (sec_stb && pend_q) |=> (now_q == $past(set_q)));
   assert_increment_R3: assert property (@(posedge clk) disable iff (rst)
      (sec_stb && !pend_q) |=> (now_q == $past(now_q) + 1'b1));
   assert_hold_between_R2: assert property (@(posedge clk) disable iff (rst)
      !sec_stb |=> $stable(now_q));
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
   import rtc_sec_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int TICK_W       = 16,
   parameter int FRAC_W       = 4,
   parameter bit FRAC_SUPPORT = 1'b1,
   parameter logic [TICK_W+FRAC_W:0] CAL_RESET = 21'h198233
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_en,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int CAL_W = TICK_W + FRAC_W + 1;

   generate
      if (DATA_W < CAL_W)  begin : g_bad_width $error("DATA_W too narrow for calibration"); end
      if (ADDR_W < 7)      begin : g_bad_addr  $error("ADDR_W cannot hold the register map"); end
      if (TICK_W < 2)      begin : g_bad_tick  $error("TICK_W too small"); end
   endgenerate

   logic             wr_set, wr_cal, wr_stat, wr_ctrl;
   logic [CAL_W-1:0] cal_q;
   logic             stat_q;
   logic             bat_q;
   logic             sec_stb;
   logic [DATA_W-1:0] set_q, now_q;

   assign wr_set  = reg_wr && (reg_addr == ADDR_W'(OFS_SET_WR));
   assign wr_cal  = reg_wr && (reg_addr == ADDR_W'(OFS_CAL));
   assign wr_stat = reg_wr && (reg_addr == ADDR_W'(OFS_STAT)) && reg_wdata[0];
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));

   always_ff @(posedge clk) begin
      if (rst) begin
         cal_q  <= CAL_RESET;
         stat_q <= 1'b0;
         bat_q  <= 1'b0;
      end else begin
         if (wr_cal)       cal_q  <= reg_wdata[CAL_W-1:0];
         if (sec_stb)      stat_q <= 1'b1;
         else if (wr_stat) stat_q <= 1'b0;
         if (wr_ctrl)      bat_q  <= reg_wdata[DATA_W-1];
      end
   end

   rtc_tick_div #(
      .TICK_W(TICK_W), .FRAC_W(FRAC_W), .FRAC_SUPPORT(FRAC_SUPPORT)
   ) u_div (
      .clk(clk), .rst(rst), .tick_en(tick_en), .cal_wr(wr_cal),
      .cal_q(cal_q), .sec_stb(sec_stb)
   );

   rtc_sec_count #(.DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst(rst), .set_wr(wr_set), .set_val(reg_wdata),
      .sec_stb(sec_stb), .set_q(set_q), .now_q(now_q)
   );

   always_comb begin
      reg_rdata = '0;
      if      (reg_addr == ADDR_W'(OFS_SET_RD)) reg_rdata = set_q;
      else if (reg_addr == ADDR_W'(OFS_CAL))    reg_rdata = DATA_W'(cal_q);
      else if (reg_addr == ADDR_W'(OFS_NOW))    reg_rdata = now_q;
      else if (reg_addr == ADDR_W'(OFS_STAT))   reg_rdata = DATA_W'(stat_q);
      else if (reg_addr == ADDR_W'(OFS_CTRL))   reg_rdata = {bat_q, {(DATA_W-1){1'b0}}};
   end

   assign irq = stat_q;

   assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
      sec_stb |=> stat_q);
   assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
      (wr_stat && !sec_stb) |=> !stat_q);
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (stat_q && !wr_stat) |=> stat_q);
endmodule

// File: tb/sim_rtc_seconds_core.sv
module sim_rtc_seconds_core;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick_en = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   rtc_seconds_core u0 (
      .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
      end
   endtask

   // Ticks needed until the current seconds value changes.
   task automatic period(output int n);
      logic [31:0] v0, v;
      rd(8'h10, v0);
      n = 0;
      v = v0;
      while (v == v0 && n < 40) begin
         ticks(1); n++;
         rd(8'h10, v);
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(8'h10, d); chk("R10 now", d, 0);
      rd(8'h04, d); chk("R10 set", d, 0);
      rd(8'h20, d); chk("R10 stat", d, 0);
      chk("R10 irq", 32'(irq), 0);
      rd(8'h08, d); chk("R10 cal", d, 32'h198233);
      rd(8'h40, d); chk("R10 ctrl", d, 0);
      rd(8'h0C, d); chk("R1 unmapped", d, 0);
   endtask

   task automatic t_load;
      logic [31:0] d;
      wr(8'h08, 32'd3);
      wr(8'h00, 32'd100);
      rd(8'h04, d); chk("R1 readback", d, 100);
      rd(8'h10, d); chk("R2 not yet", d, 0);
      ticks(2);
      rd(8'h10, d); chk("R2 before strobe", d, 0);
      rd(8'h20, d); chk("R7 no strobe yet", d, 0);
      ticks(1);
      rd(8'h10, d); chk("R2 R4 loaded on 3rd tick", d, 100);
      rd(8'h20, d); chk("R7 set", d, 1);
      chk("R8 irq high", 32'(irq), 1);
   endtask

   task automatic t_clear;
      logic [31:0] d;
      wr(8'h20, 32'hFFFF_FFFE);
      rd(8'h20, d); chk("R7 write0 ignored", d, 1);
      wr(8'h20, 32'h1);
      rd(8'h20, d); chk("R7 cleared", d, 0);
      chk("R8 irq low", 32'(irq), 0);
   endtask

   task automatic t_incr;
      logic [31:0] d;
      ticks(3);
      rd(8'h10, d); chk("R3 increment", d, 101);
      rd(8'h04, d); chk("R1 readback holds", d, 100);
   endtask

   task automatic t_restart;
      logic [31:0] d;
      ticks(2);
      wr(8'h08, 32'd3);
      ticks(2);
      rd(8'h10, d); chk("R5 no early strobe", d, 101);
      ticks(1);
      rd(8'h10, d); chk("R5 full period", d, 102);
   endtask

   task automatic t_frac;
      int p;
      wr(8'h08, (32'd1 << 20) | (32'd8 << 16) | 32'd3);
      period(p); chk("R6 sec1", 32'(p), 3);
      period(p); chk("R6 sec2", 32'(p), 3);
      period(p); chk("R6 sec3 lengthened", 32'(p), 4);
      period(p); chk("R6 sec4", 32'(p), 3);
      wr(8'h08, (32'd8 << 16) | 32'd3);
      period(p); chk("R6 trim off", 32'(p), 3);
      period(p); chk("R6 trim off again", 32'(p), 3);
   endtask

   task automatic t_ctrl;
      logic [31:0] d, v;
      wr(8'h40, 32'hFFFF_FFFF);
      rd(8'h40, d); chk("R9 ctrl readback", d, 32'h8000_0000);
      wr(8'h08, 32'd3);
      rd(8'h10, v);
      ticks(3);
      rd(8'h10, d); chk("R9 counting unaffected", d, v + 1);
      wr(8'h40, 32'h7FFF_FFFF);
      rd(8'h40, d); chk("R9 ctrl cleared", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset;
      t_load;
      t_clear;
      t_incr;
      t_restart;
      t_frac;
      t_ctrl;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule